// File: doc/BRIEF.md
# Serial-Presence EEPROM Write-Protection Controller

This block sits between the serial front end of a 256-byte configuration EEPROM and its storage array, and it decides which writes may reach the array. It holds two protection flags, one that software can set and clear again, and one that can only ever be set. Both flags are kept as registers that stand in for non-volatile cells. Either flag locks the lower half of the array, while a hardware write-protect input locks the whole array. The block also takes the device-select byte, the strap pins and a digital high-voltage qualifier on strap bit 0, and it recognises the commands that change or query the flags.

The serial shifter in front of this block hands over bus events as single-cycle strobes: a start, a stop, and each completed byte. For every byte that the slave must answer, the block returns an acknowledge decision one cycle later. Each permitted array byte appears as a buffer-write pulse that carries its address and data. At a stop the block decides whether a program cycle has to run. If so, it pulses a program start and holds a busy flag for a fixed number of cycles. The same busy window follows a flag change. While it lasts, every device-select byte is refused, so a host can poll for completion by watching for the acknowledge to return.

Top module: `spd_wp_ctrl`

## Requirements
- R1: After reset both protection flags read 0, busy is low, and the acknowledge, buffer-write and program-start outputs are all low.
- R2: A device-select byte has the form type[7:4], select[3:1] and direction[0], where direction 1 means read. A byte with type 1010 and select equal to the strap pins is acknowledged. A byte whose select differs from the straps, or whose type is neither 1010 nor 0110, is refused. Any device-select byte is refused while busy is high.
- R3: In a memory write, the first byte after the device-select byte loads the byte pointer and every later byte is data. Every address byte and data byte is acknowledged. Each permitted data byte produces a buffer-write pulse carrying the pointer and the data. After each data byte the low 4 pointer bits advance and wrap inside the 16-byte page, while the upper 4 bits stay fixed.
- R4: While the write-protect input is high, no data byte produces a buffer-write at any address, every byte is still acknowledged, and the stop starts no program cycle.
- R5: While either flag is 1, data bytes to addresses with bit 7 clear produce no buffer-write. Addresses with bit 7 set still produce a buffer-write while write-protect is low.
- R6: A stop that ends a memory write in which at least one buffer-write occurred pulses program-start for one cycle. Busy then stays high for exactly WR_CYCLES cycles.
- R7: A type-0110 byte sent while the high-voltage qualifier is high selects a software-flag command only if bit 3 is 0, bit 1 is 1, bit 2 equals strap 1, and strap 2 is low. Bit 2 = 0 selects set-soft (direction 0) or query-soft (direction 1). Bit 2 = 1 selects clear-soft (direction 0) or query-permanent (direction 1).
- R8: Set-soft and query-soft are acknowledged only when both flags are 0. Clear-soft and query-permanent are acknowledged only when the permanent flag is 0.
- R9: A type-0110 byte sent while the qualifier is low, with select equal to the straps, selects set-permanent (direction 0) or query-permanent (direction 1). It is acknowledged only when the permanent flag is 0. Once the permanent flag is 1, every type-0110 byte is refused.
- R10: A set-soft, clear-soft or set-permanent command acknowledges both of its dummy bytes. It changes its flag, pulses program-start and starts the busy window only at a stop that follows at least two dummy bytes, and only if write-protect stayed low from the start condition through the stop. Otherwise the flags keep their values.
- R11: No command sequence ever clears the permanent flag.
- R12: Query commands ignore write-protect, leave both flags unchanged and start no program cycle.
- R13: The acknowledge and buffer-write outputs are due one cycle after the byte strobe. Program-start, busy and flag updates are due one cycle after the stop strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, returns flags to 0 |
| wp_i | input | 1 | Hardware write-protect level |
| strap_i | input | 3 | Device select strap pins |
| a0_hv_i | input | 1 | High-voltage qualifier on strap bit 0 |
| start_i | input | 1 | Start or repeated-start strobe |
| stop_i | input | 1 | Stop strobe |
| byte_vld_i | input | 1 | A complete byte is available on byte_i |
| byte_i | input | 8 | Received byte |
| ack_vld_o | output | 1 | An acknowledge decision is presented |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| buf_wr_o | output | 1 | Permitted array byte |
| buf_addr_o | output | 8 | Array address of that byte |
| buf_data_o | output | 8 | Data of that byte |
| prog_start_o | output | 1 | One-cycle program cycle start |
| busy_o | output | 1 | Program cycle in progress |
| rswp_o | output | 1 | Reversible protection flag |
| pswp_o | output | 1 | Permanent protection flag |

## Verification
The acknowledge decision and any buffer-write belong to the byte strobe one clock earlier. Program-start, the new flag values and the rising edge of busy belong to the stop strobe one clock earlier, and busy then lasts WR_CYCLES clocks. The bench raises every strobe on a falling edge, lowers it on the next falling edge, and reads the outputs at that same edge, so exactly one rising edge lies between the stimulus and the sample. It measures the busy window by counting falling edges until busy drops, and no transaction starts before then, except the one that tests refusal during busy.

// File: rtl/spd_wp_pkg.sv
package spd_wp_pkg;
  localparam int ADDR_W = 8;
  localparam int PAGE_W = 4;

  typedef enum logic [2:0] {
    K_NONE, K_MEM_WR, K_MEM_RD, K_SET_R, K_CLR_R, K_QRY_R, K_SET_P, K_QRY_P
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_CMD, ST_SKIP
  } st_e;

  // write permission for one array byte
  function automatic logic may_write(input logic [ADDR_W-1:0] a, input logic wp,
                                     input logic rf, input logic pf);
    return !wp && (a[ADDR_W-1] || !(rf || pf));
  endfunction

  // advance inside the page, keep page number
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], PAGE_W'(a[PAGE_W-1:0] + 1'b1)};
  endfunction

  function automatic logic is_modify(input cmd_e k);
    return (k == K_SET_R) || (k == K_CLR_R) || (k == K_SET_P);
  endfunction
endpackage

// File: rtl/spd_wp_decode.sv
module spd_wp_decode
  import spd_wp_pkg::*;
(
  input  logic [7:0] dev,
  input  logic [2:0] strap,
  input  logic       hv,
  input  logic       rswp,
  input  logic       pswp,
  input  logic       busy,
  output cmd_e       kind,
  output logic       ack
);
  localparam logic [3:0] TYPE_MEM  = 4'b1010;
  localparam logic [3:0] TYPE_PROT = 4'b0110;

  always_comb begin
    kind = K_NONE;
    if (dev[7:4] == TYPE_MEM && dev[3:1] == strap) begin
      kind = dev[0] ? K_MEM_RD : K_MEM_WR;
    end else if (dev[7:4] == TYPE_PROT) begin
      if (hv) begin
        if (!strap[2] && !dev[3] && dev[1] && (dev[2] == strap[1]))
          kind = dev[2] ? (dev[0] ? K_QRY_P : K_CLR_R)
                        : (dev[0] ? K_QRY_R : K_SET_R);
      end else if (dev[3:1] == strap) begin
        kind = dev[0] ? K_QRY_P : K_SET_P;
      end
    end
  end

  always_comb begin
    case (kind)
      K_NONE:             ack = 1'b0;
      K_MEM_WR, K_MEM_RD: ack = 1'b1;
      K_SET_R, K_QRY_R:   ack = !rswp && !pswp;
      default:            ack = !pswp;
    endcase
    if (busy) ack = 1'b0;
  end
endmodule

// File: rtl/spd_wp_flags.sv
module spd_wp_flags
  import spd_wp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  cmd_e kind,
  output logic rswp,
  output logic pswp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rswp <= 1'b0;
      pswp <= 1'b0;
    end else if (commit) begin
      case (kind)
        K_SET_R: rswp <= 1'b1;
        K_CLR_R: rswp <= 1'b0;
        K_SET_P: pswp <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spd_wp_timer.sv
module spd_wp_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CNT_W'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/spd_wp_ctrl.sv
module spd_wp_ctrl
  import spd_wp_pkg::*;
#(
  parameter int WR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_i,
  input  logic [2:0]        strap_i,
  input  logic              a0_hv_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              buf_wr_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              prog_start_o,
  output logic              busy_o,
  output logic              rswp_o,
  output logic              pswp_o
);
  st_e               st;
  cmd_e              kind_q;
  cmd_e              dec_kind;
  logic              dec_ack;
  logic [ADDR_W-1:0] ptr;
  logic              wp_seen;
  logic [1:0]        dummies;
  logic              pend;

  // named events for the checker
  logic write_ok;
  logic flag_commit;
  logic mem_commit;
  logic prog_req;

  spd_wp_decode u_dec (
    .dev(byte_i), .strap(strap_i), .hv(a0_hv_i),
    .rswp(rswp_o), .pswp(pswp_o), .busy(busy_o),
    .kind(dec_kind), .ack(dec_ack)
  );

  assign write_ok    = may_write(ptr, wp_i, rswp_o, pswp_o);
  assign flag_commit = stop_i && (st == ST_CMD) && is_modify(kind_q) &&
                       (dummies == 2'd2) && !wp_seen && !wp_i;
  assign mem_commit  = stop_i && (st == ST_WDATA) && pend;
  assign prog_req    = flag_commit || mem_commit;

  spd_wp_flags u_flags (
    .clk(clk), .rst_n(rst_n), .commit(flag_commit), .kind(kind_q),
    .rswp(rswp_o), .pswp(pswp_o)
  );

  spd_wp_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_req), .busy(busy_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      kind_q       <= K_NONE;
      ptr          <= '0;
      wp_seen      <= 1'b0;
      dummies      <= '0;
      pend         <= 1'b0;
      ack_vld_o    <= 1'b0;
      ack_o        <= 1'b0;
      buf_wr_o     <= 1'b0;
      buf_addr_o   <= '0;
      buf_data_o   <= '0;
      prog_start_o <= 1'b0;
    end else begin
      ack_vld_o    <= 1'b0;
      ack_o        <= 1'b0;
      buf_wr_o     <= 1'b0;
      prog_start_o <= prog_req;
      if (st != ST_IDLE) wp_seen <= wp_seen || wp_i;

      if (start_i) begin
        st      <= ST_DEV;
        wp_seen <= wp_i;
        dummies <= '0;
        pend    <= 1'b0;
      end else if (stop_i) begin
        st   <= ST_IDLE;
        pend <= 1'b0;
      end else if (byte_vld_i) begin
        case (st)
          ST_DEV: begin
            ack_vld_o <= 1'b1;
            ack_o     <= dec_ack;
            kind_q    <= dec_kind;
            if (!dec_ack)                 st <= ST_SKIP;
            else if (dec_kind == K_MEM_WR) st <= ST_WADDR;
            else if (dec_kind == K_MEM_RD) st <= ST_SKIP;
            else                           st <= ST_CMD;
          end
          ST_WADDR: begin
            ack_vld_o <= 1'b1;
            ack_o     <= 1'b1;
            ptr       <= byte_i;
            st        <= ST_WDATA;
          end
          ST_WDATA: begin
            ack_vld_o <= 1'b1;
            ack_o     <= 1'b1;
            if (write_ok) begin
              buf_wr_o   <= 1'b1;
              buf_addr_o <= ptr;
              buf_data_o <= byte_i;
              pend       <= 1'b1;
            end
            ptr <= page_next(ptr);
          end
          ST_CMD: begin
            if (is_modify(kind_q)) begin
              ack_vld_o <= 1'b1;
              ack_o     <= 1'b1;
              if (dummies != 2'd2) dummies <= dummies + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spd_wp_chk.sv
module spd_wp_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wp_i,
  input logic          stop_i,
  input logic          byte_vld_i,
  input logic          ack_vld_o,
  input logic          ack_o,
  input logic          buf_wr_o,
  input logic [AW-1:0] buf_addr_o,
  input logic          prog_start_o,
  input logic          busy_o,
  input logic          rswp_o,
  input logic          pswp_o
);
  a_r11_pswp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(pswp_o));

  a_r4_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_o |-> !$past(wp_i));

  a_r5_lower_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_o && !buf_addr_o[AW-1]) |-> !($past(rswp_o) || $past(pswp_o)));

  a_r10_flag_needs_prog: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rswp_o) || $fell(rswp_o) || $rose(pswp_o)) |-> prog_start_o);

  a_r6_prog_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |-> busy_o);

  a_r13_prog_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |-> $past(stop_i));

  a_r13_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o |-> $past(byte_vld_i));

  a_r3_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_o |-> (ack_vld_o && ack_o));
endmodule

bind spd_wp_ctrl spd_wp_chk #(.AW(spd_wp_pkg::ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .stop_i(stop_i),
  .byte_vld_i(byte_vld_i), .ack_vld_o(ack_vld_o), .ack_o(ack_o),
  .buf_wr_o(buf_wr_o), .buf_addr_o(buf_addr_o), .prog_start_o(prog_start_o),
  .busy_o(busy_o), .rswp_o(rswp_o), .pswp_o(pswp_o)
);

// File: tb/spd_wp_ctrl_tb.sv
module spd_wp_ctrl_tb;
  localparam int WRC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_i = 1'b0;
  logic [2:0] strap_i = 3'b000;
  logic       a0_hv_i = 1'b0;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       ack_vld_o, ack_o, buf_wr_o, prog_start_o, busy_o, rswp_o, pswp_o;
  logic [7:0] buf_addr_o, buf_data_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  bit rm = 1'b0;
  bit pm = 1'b0;

  always #10 clk = ~clk;

  spd_wp_ctrl #(.WR_CYCLES(WRC)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench view: 0 none,1 mem wr,2 mem rd,3 set soft,4 clear soft,5 query soft,6 set perm,7 query perm
  function automatic int model_kind(input logic [7:0] b, input logic [2:0] s, input bit hv);
    int t = int'(b) / 16;
    int sel = (int'(b) / 2) % 8;
    int rd = int'(b) % 2;
    if (t == 10) return (sel == int'(s)) ? 1 + rd : 0;
    if (t != 6) return 0;
    if (!hv) return (sel == int'(s)) ? 6 + rd : 0;
    if (s[2] || b[3] || !b[1] || (b[2] != s[1])) return 0;
    if (b[2]) return rd ? 7 : 4;
    return rd ? 5 : 3;
  endfunction

  function automatic bit model_ack(input int k);
    case (k)
      0: return 1'b0;
      1, 2: return 1'b1;
      3, 5: return !(rm || pm);
      default: return !pm;
    endcase
  endfunction

  function automatic bit model_wr(input logic [7:0] a, input bit wp);
    if (wp) return 1'b0;
    if (a >= 8'h80) return 1'b1;
    return !rm && !pm;
  endfunction

  task automatic tx_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic tx_byte(input logic [7:0] b);
    byte_i = b;
    byte_vld_i = 1'b1;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic tx_stop();
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  task automatic wait_busy(input string tag);
    int n = 1;
    for (int i = 0; i < WRC + 5; i++) begin
      @(negedge clk);
      if (!busy_o) break;
      n++;
    end
    chk(n == WRC, tag, n, WRC);
  endtask

  task automatic do_write(input logic [2:0] s, input logic [7:0] addr, input int n, input bit wp);
    logic [7:0] cur = addr;
    bit any = 1'b0;
    string tag;
    strap_i = s; a0_hv_i = 1'b0; wp_i = wp;
    tx_start();
    tx_byte({4'b1010, s, 1'b0});
    chk(ack_vld_o && ack_o, "R2 mem select ack", ack_o, 1);
    tx_byte(addr);
    chk(ack_vld_o && ack_o, "R3 address ack", ack_o, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      bit e = model_wr(cur, wp);
      tag = wp ? "R4 wp data" : ((cur < 8'h80 && (rm || pm)) ? "R5 lower guard" : "R3 data");
      tx_byte(d);
      chk(ack_vld_o && ack_o, tag, ack_o, 1);
      chk(buf_wr_o == e, tag, buf_wr_o, e);
      if (e) begin
        chk(buf_addr_o == cur, "R3 address/wrap", buf_addr_o, cur);
        chk(buf_data_o == d, "R3 data", buf_data_o, d);
      end
      any |= e;
      cur = {cur[7:4], 4'(cur[3:0] + 1'b1)};
    end
    tx_stop();
    chk(prog_start_o == any, wp ? "R4 no program" : "R6 program start", prog_start_o, any);
    chk(busy_o == any, "R6 busy", busy_o, any);
    if (any) wait_busy("R6 busy length");
    wp_i = 1'b0;
  endtask

  task automatic do_cmd(input logic [7:0] dev, input logic [2:0] s, input bit hv,
                        input bit wp, input int ndum, input bit glitch, input string tag);
    int k = model_kind(dev, s, hv);
    bit ea = model_ack(k);
    bit md = (k == 3) || (k == 4) || (k == 6);
    bit commit;
    strap_i = s; a0_hv_i = hv; wp_i = wp;
    tx_start();
    tx_byte(dev);
    chk(ack_vld_o && (ack_o == ea), tag, ack_o, ea);
    if (ea && md) begin
      for (int i = 0; i < ndum; i++) begin
        tx_byte(8'($urandom));
        chk(ack_vld_o && ack_o, "R10 dummy ack", ack_o, 1);
      end
    end
    if (glitch) begin
      wp_i = 1'b1; @(negedge clk); wp_i = 1'b0;
    end
    commit = ea && md && (ndum >= 2) && !wp && !glitch;
    tx_stop();
    chk(prog_start_o == commit, md ? "R10 commit" : "R12 query no program", prog_start_o, commit);
    if (commit) begin
      if (k == 3) rm = 1'b1;
      if (k == 4) rm = 1'b0;
      if (k == 6) pm = 1'b1;
    end
    chk(rswp_o == rm, "R10 soft flag", rswp_o, rm);
    chk(pswp_o == pm, "R11 perm flag", pswp_o, pm);
    if (commit) wait_busy("R10 busy length");
    a0_hv_i = 1'b0; wp_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(!rswp_o && !pswp_o, "R1 flags", {rswp_o, pswp_o}, 0);
    chk(!busy_o && !ack_vld_o && !ack_o, "R1 busy/ack", busy_o, 0);
    chk(!buf_wr_o && !prog_start_o, "R1 write/program", buf_wr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_write(3'b000, 8'h90, 3, 1'b0);
    do_write(3'b101, 8'h3E, 5, 1'b0);          // R3 page wrap
    do_write(3'b000, 8'h10, 4, 1'b1);          // R4
    do_write(3'b000, 8'hC0, 2, 1'b1);          // R4

    // wrong select and busy refusal (R2)
    strap_i = 3'b010;
    tx_start(); tx_byte(8'hA0);
    chk(ack_vld_o && !ack_o, "R2 wrong select", ack_o, 0);
    tx_stop();
    tx_start(); tx_byte(8'h50);
    chk(ack_vld_o && !ack_o, "R2 foreign type", ack_o, 0);
    tx_stop();
    strap_i = 3'b000;
    tx_start(); tx_byte(8'hA0); tx_byte(8'hA0); tx_byte(8'h11); tx_stop();
    chk(prog_start_o && busy_o, "R6 program start", busy_o, 1);
    tx_start(); tx_byte(8'hA0);
    chk(ack_vld_o && !ack_o, "R2 busy refusal", ack_o, 0);
    tx_stop();
    for (int i = 0; i < WRC + 2; i++) @(negedge clk);
    chk(!busy_o, "R6 busy ends", busy_o, 0);

    // soft flag set and its refusals (R7, R8)
    do_cmd(8'h62, 3'b000, 1'b1, 1'b0, 2, 1'b0, "R7 set soft ack");
    do_cmd(8'h62, 3'b000, 1'b1, 1'b0, 2, 1'b0, "R8 set soft again refused");
    do_cmd(8'h63, 3'b000, 1'b1, 1'b1, 0, 1'b0, "R12 query soft with wp high");
    do_cmd(8'h62, 3'b000, 1'b0, 1'b0, 2, 1'b0, "R9 no qualifier means permanent");
    rm = rm; // unchanged unless model committed
    do_write(3'b000, 8'h20, 3, 1'b0);          // R5 lower blocked
    do_write(3'b000, 8'hA0, 3, 1'b0);          // R5 upper open
    do_cmd(8'h66, 3'b010, 1'b1, 1'b1, 2, 1'b0, "R10 clear with wp high");
    do_cmd(8'h66, 3'b010, 1'b1, 1'b0, 2, 1'b1, "R10 clear with wp glitch");
    do_cmd(8'h66, 3'b010, 1'b1, 1'b0, 1, 1'b0, "R10 clear short");
    do_cmd(8'h66, 3'b010, 1'b1, 1'b0, 2, 1'b0, "R7 clear soft");
    do_cmd(8'h66, 3'b110, 1'b1, 1'b0, 2, 1'b0, "R7 strap2 high refused");
    do_cmd(8'h62, 3'b000, 1'b1, 1'b0, 2, 1'b0, "R7 set soft");
    do_cmd(8'h66, 3'b010, 1'b1, 1'b0, 2, 1'b0, "R7 clear soft again");

    // random mix (pm stays 0 here)
    for (int it = 0; it < 200; it++) begin
      int sel = int'($urandom % 3);
      if (sel == 0) begin
        do_write(3'($urandom), 8'($urandom), 1 + int'($urandom % 20), ($urandom % 4) == 0);
      end else if (sel == 1) begin
        int c = int'($urandom % 4);
        bit wp = ($urandom % 4) == 0;
        int nd = int'($urandom % 3);
        logic [2:0] s;
        logic [7:0] dv;
        case (c)
          0: begin s = 3'b000; dv = 8'h62; end
          1: begin s = 3'b010; dv = 8'h66; end
          2: begin s = 3'b000; dv = 8'h63; end
          default: begin s = 3'b010; dv = 8'h67; end
        endcase
        s[0] = 1'($urandom);
        do_cmd(dv, s, 1'b1, wp, nd, 1'b0, "R8 random soft command");
      end else begin
        logic [7:0] dv = 8'($urandom);
        logic [2:0] s = 3'($urandom);
        bit hv = 1'($urandom);
        if (model_kind(dv, s, hv) == 6) dv[0] = 1'b1;
        do_cmd(dv, s, hv, 1'($urandom), 0, 1'b0, "R2 random select byte");
      end
    end

    // permanent flag (R9, R11)
    do_cmd(8'h6A, 3'b101, 1'b0, 1'b0, 2, 1'b0, "R9 set permanent");
    do_cmd(8'h6B, 3'b101, 1'b0, 1'b0, 0, 1'b0, "R9 query permanent refused");
    do_cmd(8'h6A, 3'b101, 1'b0, 1'b0, 2, 1'b0, "R9 set permanent again refused");
    do_cmd(8'h66, 3'b010, 1'b1, 1'b0, 2, 1'b0, "R11 clear soft refused");
    do_cmd(8'h62, 3'b000, 1'b1, 1'b0, 2, 1'b0, "R9 set soft refused");
    do_cmd(8'h67, 3'b010, 1'b1, 1'b0, 0, 1'b0, "R8 query permanent refused");
    do_write(3'b000, 8'h05, 3, 1'b0);
    do_write(3'b000, 8'hF5, 3, 1'b0);
    chk(pswp_o, "R11 still set", pswp_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule